// File: doc/BRIEF.md
# Debounced Two-Button Up/Down Counter

This block keeps an 8-bit count and shows it on eight LED outputs. Two mechanical push buttons control the count. One button raises it by one and the other lowers it by one. Both button lines arrive raw, so they are asynchronous to the system clock and bounce for several milliseconds after each change.

Each button line goes through three stages in turn. A two-flop synchronizer comes first. A counter-based stability filter follows and acts as a digital low-pass. A rising-edge detector comes last and turns each real press into a one-cycle step request. Only the system clock clocks any register. The buttons never act as clocks or as asynchronous set or clear inputs.

The filter length is a parameter. The default of 2^20 cycles is about 21 ms at 50 MHz. A bench can set a short length to exercise the same behaviour in a few cycles.

Top module: `updn_counter_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising clock edge sets `led_count` to 0 at that edge. It also sets the filtered levels and the edge history to 0, so no step is taken in the cycle after reset while the buttons are released.
- R2: A press of `btn_up_raw` adds one to `led_count`. A press means the line is held at 1 for at least `DEBOUNCE_CYCLES` cycles after synchronization.
- R3: A press of `btn_dn_raw` subtracts one from `led_count`.
- R4: A press held for any length of time changes the count exactly once. Releasing the button changes nothing.
- R5: A new level that lasts fewer than `DEBOUNCE_CYCLES` consecutive cycles never reaches the counter. Any return to the old level during the window restarts the stability count, so a bouncing press still counts only once.
- R6: In every cycle without a step request, `led_count` keeps its value.
- R7: If the up and down step requests occur in the same cycle, `led_count` is left unchanged.
- R8: The count wraps modulo 2^`COUNT_W`. Up from 8'hFF gives 8'h00, and down from 8'h00 gives 8'hFF.
- R9: Let raw edge 0 be the first clock edge that samples a raw line at its new pressed level. `led_count` changes at clock edge `DEBOUNCE_CYCLES`+2 counted from raw edge 0. Two edges go to the synchronizer, `DEBOUNCE_CYCLES` edges to the filter, and one edge to the count register.
- R10: A step request is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_up_raw | input | 1 | Raw, bouncy "count up" button, 1 = pressed |
| btn_dn_raw | input | 1 | Raw, bouncy "count down" button, 1 = pressed |
| led_count | output | COUNT_W (8) | Current count, drives the LEDs directly |

## Verification
The up and down step requests can fall in the same clock cycle. The bench provokes this by raising both raw lines on the same clock edge. Both lines then pass through identical synchronizer and filter chains, so their step requests line up exactly. The count is judged after both buttons are released and have settled, and it must equal its value from before the double press. The checker also asserts, cycle by cycle, that the count is stable after any cycle in which both requests were present.

// File: rtl/updn_btn_pkg.sv
package updn_btn_pkg;

    localparam int BTN_UP   = 0;
    localparam int BTN_DN   = 1;
    localparam int NUM_BTNS = 2;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic up;
        logic dn;
    } press_t;

    // Both or neither request -> hold; one alone picks the direction.
    function automatic step_e decode_step(press_t p);
        step_e s;
        case ({p.up, p.dn})
            2'b10:   s = STEP_INC;
            2'b01:   s = STEP_DEC;
            default: s = STEP_HOLD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
        end
    end

    assign dout = shift_q[STAGES-1];
endmodule

// File: rtl/updn_debounce.sv
module updn_debounce #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (din == level_q) begin
            run_q <= '0;                 // agreement restarts the window
        end else if (run_q == LAST) begin
            level_q <= din;
            run_q   <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end

    assign level = level_q;
endmodule

// File: rtl/updn_rise.sv
module updn_rise (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    assign pulse = level & ~prev_q;
endmodule

// File: rtl/updn_counter_top.sv
module updn_counter_top
    import updn_btn_pkg::*;
#(
    parameter int COUNT_W         = 8,
    parameter int DEBOUNCE_CYCLES = 1 << 20,
    parameter int SYNC_STAGES     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_up_raw,
    input  logic               btn_dn_raw,
    output logic [COUNT_W-1:0] led_count
);
    logic [NUM_BTNS-1:0] raw_w;
    logic [NUM_BTNS-1:0] synced_w;
    logic [NUM_BTNS-1:0] level_w;
    logic [NUM_BTNS-1:0] pulse_w;

    assign raw_w[BTN_UP] = btn_up_raw;
    assign raw_w[BTN_DN] = btn_dn_raw;

    for (genvar g = 0; g < NUM_BTNS; g++) begin : g_chain
        updn_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_w[g]),
            .dout (synced_w[g])
        );
        updn_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) deb_i (
            .clk   (clk),
            .rst   (rst),
            .din   (synced_w[g]),
            .level (level_w[g])
        );
        updn_rise rise_i (
            .clk   (clk),
            .rst   (rst),
            .level (level_w[g]),
            .pulse (pulse_w[g])
        );
    end

    press_t press;
    step_e  step;

    assign press.up = pulse_w[BTN_UP];
    assign press.dn = pulse_w[BTN_DN];
    assign step     = decode_step(press);

    logic [COUNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (step)
                STEP_INC: count_q <= count_q + COUNT_W'(1);
                STEP_DEC: count_q <= count_q - COUNT_W'(1);
                default:  count_q <= count_q;
            endcase
        end
    end

    assign led_count = count_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
    parameter int COUNT_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               up_p,
    input logic               dn_p,
    input logic [COUNT_W-1:0] count
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count == '0) && !up_p && !dn_p);                              // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (up_p && !dn_p) |=> ((count - $past(count)) == COUNT_W'(1)));          // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (dn_p && !up_p) |=> (($past(count) - count) == COUNT_W'(1)));          // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!up_p && !dn_p) |=> $stable(count));                                  // R6

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (up_p && dn_p) |=> $stable(count));                                    // R7

    AST_UP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        up_p |=> !up_p);                                                       // R10

    AST_DN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dn_p |=> !dn_p);                                                       // R10
endmodule

bind updn_counter_top updn_counter_chk #(.COUNT_W(COUNT_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .up_p  (pulse_w[0]),
    .dn_p  (pulse_w[1]),
    .count (led_count)
);

// File: tb/updn_counter_top_tb_top.sv
`timescale 1ns/1ps
module updn_counter_top_tb_top;
    localparam int DEB    = 4;
    localparam int SETTLE = DEB + 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_raw = 1'b0;
    logic       dn_raw = 1'b0;
    logic [7:0] count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    updn_counter_top #(
        .COUNT_W(8), .DEBOUNCE_CYCLES(DEB), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst),
        .btn_up_raw(up_raw), .btn_dn_raw(dn_raw),
        .led_count(count)
    );

    typedef struct packed {
        logic       up;
        logic       dn;
        logic [7:0] exp;
    } vec_t;

    // Starting from count 0 after reset.
    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 8'd1},    // R2
        '{1'b1, 1'b0, 8'd2},    // R2
        '{1'b1, 1'b0, 8'd3},    // R2
        '{1'b0, 1'b1, 8'd2},    // R3
        '{1'b1, 1'b1, 8'd2},    // R7 simultaneous
        '{1'b0, 1'b1, 8'd1},    // R3
        '{1'b0, 1'b1, 8'd0},    // R3
        '{1'b0, 1'b1, 8'd255},  // R8 wrap down
        '{1'b1, 1'b0, 8'd0}     // R8 wrap up
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_tests++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: led_count=%0d expected=%0d", req, count, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic press(input logic u, input logic d, input int hold);
        up_raw = u;
        dn_raw = d;
        cycles(hold);
        up_raw = 1'b0;
        dn_raw = 1'b0;
        cycles(SETTLE);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(1);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset value", 8'd0);
        cycles(5);
        check("R1 no step after reset", 8'd0);

        for (int i = 0; i < 9; i++) begin
            press(VECS[i].up, VECS[i].dn, SETTLE);
            check($sformatf("R2/R3/R7/R8 vector %0d", i), VECS[i].exp);
        end

        // R9: exact latency, starting from 0
        up_raw = 1'b1;
        cycles(DEB + 2);
        check("R9 before latency", 8'd0);
        cycles(1);
        check("R9 at latency", 8'd1);
        // R4: long hold counts once
        cycles(60);
        check("R4 long hold", 8'd1);
        up_raw = 1'b0;
        cycles(SETTLE * 2);
        check("R4 release no change", 8'd1);

        // R5: glitch of DEB-1 cycles rejected
        up_raw = 1'b1;
        cycles(DEB - 1);
        up_raw = 1'b0;
        cycles(SETTLE);
        check("R5 short glitch", 8'd1);

        // R5: bouncing press counts once
        for (int b = 0; b < 5; b++) begin
            up_raw = 1'b1;
            cycles(2);
            up_raw = 1'b0;
            cycles(1);
        end
        up_raw = 1'b1;
        cycles(SETTLE);
        for (int b = 0; b < 4; b++) begin
            up_raw = 1'b0;
            cycles(2);
            up_raw = 1'b1;
            cycles(1);
        end
        up_raw = 1'b0;
        cycles(SETTLE);
        check("R5 bouncing press", 8'd2);

        // R6: idle cycles hold
        cycles(40);
        check("R6 idle hold", 8'd2);

        // R10 seen at ports: one down press moves by exactly one
        press(1'b0, 1'b1, SETTLE);
        check("R10 single step", 8'd1);

        // R1: reset from nonzero
        press(1'b1, 1'b0, SETTLE);
        press(1'b1, 1'b0, SETTLE);
        check("R2 before reset", 8'd3);
        rst = 1'b1;
        cycles(1);
        check("R1 clear from nonzero", 8'd0);
        rst = 1'b0;
        cycles(SETTLE);
        check("R1 stays clear", 8'd0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule